// File: doc/BRIEF.md
# Four-Channel PWM Controller

This block produces four pulse-width-modulated outputs from one system clock and exposes their configuration through a small word-addressed register window. Each channel's rate comes from two divide stages in series. The first stage is an 8-bit prescaler, and each pair of channels shares one. The second stage is a per-channel selector that divides by a power of two or passes the prescaled rate through unchanged. The resulting tick drives a 16-bit down-counter. The counter sets the period, and a 16-bit compare value sets the high time.

All division is done with single-cycle enable pulses in the one clock domain, so no derived clocks are created. Software configures a channel and then sets its enable and continuous-mode bits. The pin can be inverted at any time, and the live counter of each channel can be read back. Interrupt-enable, interrupt-status and watchdog-style registers are present in the map only as locations that ignore writes and read as zero.

Top module: `pwm4_ctrl`

## Requirements
- R1: Only accesses with address bits 1:0 equal to 0 take effect. Other accesses are ignored, and a read of such an address returns 0. Read data appears on `rdata_o` one clock after the read request. Map: prescale word at 0x00, selector word at 0x04, control word at 0x08. Channel n has its period at 0x0C+12n, its compare at 0x10+12n and its counter at 0x14+12n.
- R2: The prescale word holds two 8-bit fields. Channels 0 and 1 use bits 7:0, and channels 2 and 3 use bits 15:8. A field value p divides the system clock by p+1.
- R3: The selector word holds a 3-bit field for channel n at bit 4n. A value s from 0 to 3 divides the prescaled rate by 2^(s+1). A value of 4 passes the prescaled rate through.
- R4: Selector values 5, 6 and 7 behave exactly like 4.
- R5: The control word holds a 4-bit field per channel at bit offsets 0, 8, 12 and 16. In each field, bit 0 enables the channel, bit 2 inverts the pin and bit 3 selects continuous mode. A channel runs only when both bit 0 and bit 3 are set. Otherwise its un-inverted level is low.
- R6: A running channel repeats a period of (period value + 1) selector ticks. It is high for (compare value + 1) of those ticks, before inversion.
- R7: When the compare value is greater than or equal to a non-zero period value, the level is high for the whole period. A period value of 0 holds the level low.
- R8: When the invert bit is set, the pin is the complement of the computed level. This includes a stopped channel, whose pin then reads 1.
- R9: A write of more than 65535 to a period or compare register stores 65535. Smaller values are stored as written.
- R10: A counter register reads the channel's live counter. A stopped channel's counter holds its period value. Writes to the counter registers, and to 0x3C, 0x40 and 0x44 to 0x50, change nothing, and those last locations read 0.
- R11: After reset all registers read 0 and all pins are low.
- R12: A running counter counts down to 0 and then reloads. New period and compare values take effect only at that reload point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| pwm_o | output | 4 | PWM pins, one per channel |

## Verification
A write lands on the clock edge that samples it. A register read answers on the following edge, so the bench drives each request at a falling edge and takes `rdata_o` at the next falling edge.

Pin levels follow register writes from the edge after the write. The phase of the divider chain at that point is not fixed, so waveform checks do not count from the write. Instead, the bench locks onto a rising edge of the pin and then measures the cycles to the next rising edge and the number of high samples over four whole periods. Both are taken at falling edges and compared with (prescale + 1) x selector divisor x (period value + 1), and with the matching high count.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int NCH       = 4;
  localparam int NPAIR     = NCH / 2;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 16;
  localparam int PSC_W     = 8;
  localparam int SEL_W     = 3;
  localparam int SDIV_W    = 4;
  localparam int CH_STRIDE = 12;

  localparam logic [ADDR_W-1:0] A_PSC     = 12'h000;
  localparam logic [ADDR_W-1:0] A_SEL     = 12'h004;
  localparam logic [ADDR_W-1:0] A_CTL     = 12'h008;
  localparam logic [ADDR_W-1:0] A_CH_BASE = 12'h00C;
  localparam logic [ADDR_W-1:0] A_IEN     = 12'h03C;

  function automatic int ctl_lsb(int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int sel_lsb(int ch);
    return 4 * ch;
  endfunction

  function automatic logic [ADDR_W-1:0] per_addr(int ch);
    return A_CH_BASE + ADDR_W'(CH_STRIDE * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_addr(int ch);
    return A_CH_BASE + ADDR_W'(CH_STRIDE * ch + 4);
  endfunction

  function automatic logic [ADDR_W-1:0] cnt_addr(int ch);
    return A_CH_BASE + ADDR_W'(CH_STRIDE * ch + 8);
  endfunction
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NCH-1:0][CNT_W-1:0]      cnt_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NPAIR-1:0][PSC_W-1:0]    psc_o,
  output logic [NCH-1:0][SEL_W-1:0]      sel_o,
  output logic [NCH-1:0]                 run_o,
  output logic [NCH-1:0]                 inv_o,
  output logic [NCH-1:0][CNT_W-1:0]      per_o,
  output logic [NCH-1:0][CNT_W-1:0]      cmp_o
);
  logic [DATA_W-1:0] psc_q, sel_q, ctl_q, rmux, rdata_q;
  logic [NCH-1:0][CNT_W-1:0] per_q, cmp_q;
  logic aligned, wr, rd;
  logic [CNT_W-1:0] wclamp;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i & aligned;
  assign rd      = req_i & ~we_i & aligned;
  assign wclamp  = (|wdata_i[DATA_W-1:CNT_W]) ? '1 : wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      sel_q <= '0;
      ctl_q <= '0;
      per_q <= '0;
      cmp_q <= '0;
    end else if (wr) begin
      if (addr_i == A_PSC) psc_q <= wdata_i;
      if (addr_i == A_SEL) sel_q <= wdata_i;
      if (addr_i == A_CTL) ctl_q <= wdata_i;
      for (int i = 0; i < NCH; i++) begin
        if (addr_i == per_addr(i)) per_q[i] <= wclamp;
        if (addr_i == cmp_addr(i)) cmp_q[i] <= wclamp;
      end
    end
  end

  always_comb begin
    rmux = '0;
    if (addr_i == A_PSC) rmux = psc_q;
    if (addr_i == A_SEL) rmux = sel_q;
    if (addr_i == A_CTL) rmux = ctl_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == per_addr(i)) rmux = DATA_W'(per_q[i]);
      if (addr_i == cmp_addr(i)) rmux = DATA_W'(cmp_q[i]);
      if (addr_i == cnt_addr(i)) rmux = DATA_W'(cnt_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rmux : '0;
  end

  assign rdata_o = rdata_q;
  assign per_o   = per_q;
  assign cmp_o   = cmp_q;

  for (genvar p = 0; p < NPAIR; p++) begin : g_psc
    assign psc_o[p] = psc_q[PSC_W*p +: PSC_W];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_fld
    assign sel_o[i] = sel_q[sel_lsb(i) +: SEL_W];
    assign run_o[i] = ctl_q[ctl_lsb(i)] & ctl_q[ctl_lsb(i) + 3];
    assign inv_o[i] = ctl_q[ctl_lsb(i) + 2];
  end
endmodule

// File: rtl/pwm4_div.sv
module pwm4_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, lim_q;
  logic same;

  assign same = (lim_i == lim_q);

  // a changed limit restarts the stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      lim_q <= lim_i;
      if (!same)     cnt_q <= '0;
      else if (en_i) cnt_q <= (cnt_q == lim_i) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i & same & (cnt_q == lim_i);
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          inv_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] cmp_i,
  output logic [CW-1:0] cnt_o,
  output logic          pwm_o
);
  logic [CW-1:0] cnt_q, per_q, cmp_q;
  logic lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      cmp_q <= '0;
    end else if (!run_i) begin
      cnt_q <= per_i;
      per_q <= per_i;
      cmp_q <= cmp_i;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_q <= per_i;
        per_q <= per_i;
        cmp_q <= cmp_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // high during the first cmp+1 ticks of each period
  assign lvl = run_i & (per_q != '0) &
               ((cmp_q >= per_q) | (cnt_q >= per_q - cmp_q));
  assign pwm_o = lvl ^ inv_i;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  logic [NPAIR-1:0][PSC_W-1:0] psc_w;
  logic [NCH-1:0][SEL_W-1:0]   sel_w;
  logic [NCH-1:0]              run_w, inv_w;
  logic [NCH-1:0][CNT_W-1:0]   per_w, cmp_w, cnt_w;
  logic [NPAIR-1:0]            psc_tick;
  logic [NCH-1:0]              sel_tick;
  logic [NCH-1:0][SDIV_W-1:0]  sel_lim;

  pwm4_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_i   (cnt_w),
    .rdata_o (rdata_o),
    .psc_o   (psc_w),
    .sel_o   (sel_w),
    .run_o   (run_w),
    .inv_o   (inv_w),
    .per_o   (per_w),
    .cmp_o   (cmp_w)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm4_div #(.W(PSC_W)) i_psc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (1'b1),
      .lim_i  (psc_w[p]),
      .tick_o (psc_tick[p])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // selector 4..7: bypass
    assign sel_lim[i] = (sel_w[i] >= SEL_W'(4)) ? '0
                        : SDIV_W'((32'd2 << sel_w[i]) - 32'd1);

    pwm4_div #(.W(SDIV_W)) i_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (psc_tick[i/2]),
      .lim_i  (sel_lim[i]),
      .tick_o (sel_tick[i])
    );

    pwm4_chan #(.CW(CNT_W)) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (sel_tick[i]),
      .run_i  (run_w[i]),
      .inv_i  (inv_w[i]),
      .per_i  (per_w[i]),
      .cmp_i  (cmp_w[i]),
      .cnt_o  (cnt_w[i]),
      .pwm_o  (pwm_o[i])
    );
  end
endmodule

// File: rtl/pwm4_ctrl_chk.sv
module pwm4_ctrl_chk
  import pwm4_pkg::*;
(
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        req_i,
  input logic                        we_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [DATA_W-1:0]           wdata_i,
  input logic [NCH-1:0]              pwm_o,
  input logic [NPAIR-1:0][PSC_W-1:0] psc_w,
  input logic [NCH-1:0][SEL_W-1:0]   sel_w,
  input logic [NCH-1:0]              run_w,
  input logic [NCH-1:0]              inv_w,
  input logic [NCH-1:0][CNT_W-1:0]   per_w,
  input logic [NCH-1:0][CNT_W-1:0]   cmp_w,
  input logic [NCH-1:0][CNT_W-1:0]   cnt_w,
  input logic [NPAIR-1:0]            psc_tick,
  input logic [NCH-1:0]              sel_tick
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r8_stopped_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_w[i] |-> pwm_o[i] == inv_w[i]);

    a_r6_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_w[i] && sel_tick[i] && cnt_w[i] != '0 |=> cnt_w[i] == $past(cnt_w[i]) - 1'b1);

    a_r6_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_w[i] && !sel_tick[i] |=> $stable(cnt_w[i]));

    a_r12_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_w[i] && sel_tick[i] && cnt_w[i] == '0 |=> cnt_w[i] == $past(per_w[i]));

    a_r3_nested_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_tick[i] |-> psc_tick[i/2]);

    a_r9_clamp_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i && we_i && addr_i == per_addr(i) && (|wdata_i[DATA_W-1:CNT_W])
      |=> per_w[i] == '1);

    a_r10_ignored_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i && we_i && (addr_i == cnt_addr(i) || addr_i >= A_IEN)
      |=> $stable(per_w) && $stable(cmp_w) && $stable(run_w) && $stable(inv_w)
          && $stable(sel_w) && $stable(psc_w));
  end
endmodule

bind pwm4_ctrl pwm4_ctrl_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pwm_o    (pwm_o),
  .psc_w    (psc_w),
  .sel_w    (sel_w),
  .run_w    (run_w),
  .inv_w    (inv_w),
  .per_w    (per_w),
  .cmp_w    (cmp_w),
  .cnt_w    (cnt_w),
  .psc_tick (psc_tick),
  .sel_tick (sel_tick)
);

// File: tb/test_pwm4_ctrl.sv
module test_pwm4_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    int ch; int psc; int sel; int per; int cmp; int inv; int exp_per; int exp_hi;
  } vec_t;

  // exp_per 0: constant pin, exp_hi then holds its level
  localparam vec_t VECS [10] = '{
    '{0, 0, 4, 3, 1, 0,  4,  2},
    '{1, 1, 0, 4, 0, 0, 20,  4},
    '{2, 2, 1, 2, 1, 0, 36, 24},
    '{3, 0, 7, 5, 2, 1,  6,  3},
    '{0, 0, 2, 1, 0, 0, 16,  8},
    '{1, 0, 4, 2, 9, 0,  0,  1},
    '{2, 0, 4, 0, 0, 0,  0,  0},
    '{3, 0, 3, 1, 0, 0, 32, 16},
    '{0, 0, 5, 7, 6, 1,  8,  1},
    '{2, 0, 4, 0, 5, 1,  0,  1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm4_ctrl i_pwm4_ctrl (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pwm_o   (pwm)
  );

  function automatic int ctl_sh(int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a[11:0]; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a[11:0];
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rd_check(string tag, int a, int exp);
    int v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic measure(string tag, int ch, int per, int hi);
    int prev, cur, n, h;
    h = 0;
    if (per == 0) begin
      for (int k = 0; k < 64; k++) begin
        @(negedge clk);
        h += int'(pwm[ch]);
      end
      check({tag, " level"}, h, 64 * hi);
    end else begin
      n = 0;
      @(negedge clk);
      prev = int'(pwm[ch]);
      while (n < 5000) begin
        @(negedge clk);
        cur = int'(pwm[ch]);
        n++;
        if (prev == 0 && cur == 1) break;
        prev = cur;
      end
      n = 0;
      prev = 1;
      while (n < 5000) begin
        @(negedge clk);
        cur = int'(pwm[ch]);
        n++;
        if (prev == 0 && cur == 1) break;
        prev = cur;
      end
      check({tag, " period"}, n, per);
      for (int k = 0; k < 4 * per; k++) begin
        @(negedge clk);
        h += int'(pwm[ch]);
      end
      check({tag, " high"}, h, 4 * hi);
    end
  endtask

  task automatic setup(int ch, int psc, int sel, int per, int cmp, int ctl);
    wr(32'h008, 0);
    wr(32'h000, psc << (8 * (ch / 2)));
    wr(32'h004, sel << (4 * ch));
    wr(32'h00C + 12 * ch, per);
    wr(32'h010 + 12 * ch, cmp);
    wr(32'h008, ctl << ctl_sh(ch));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11 pins", int'(pwm), 0);
    rd_check("R11 prescale", 32'h000, 0);
    rd_check("R11 selector", 32'h004, 0);
    rd_check("R11 control", 32'h008, 0);
    rd_check("R11 period0", 32'h00C, 0);
    rd_check("R11 compare3", 32'h034, 0);
    rd_check("R11 counter1", 32'h020, 0);

    // R2 R3 R4 R6 R7 R8 waveform table
    for (int i = 0; i < 10; i++) begin
      setup(VECS[i].ch, VECS[i].psc, VECS[i].sel, VECS[i].per, VECS[i].cmp,
            9 | (VECS[i].inv << 2));
      repeat (4) @(negedge clk);
      measure($sformatf("R6 vec%0d", i), VECS[i].ch, VECS[i].exp_per, VECS[i].exp_hi);
    end

    // R9 clamping
    wr(32'h008, 0);
    wr(32'h00C, 32'h0001_2345);
    rd_check("R9 period clamp", 32'h00C, 65535);
    wr(32'h01C, 32'h0001_0000);
    rd_check("R9 compare clamp", 32'h01C, 65535);
    wr(32'h018, 7);
    rd_check("R9 small value", 32'h018, 7);

    // R10 counter and ignored locations
    wr(32'h00C, 10);
    rd_check("R10 stopped counter", 32'h014, 10);
    wr(32'h014, 55);
    rd_check("R10 counter write ignored", 32'h014, 10);
    rd_check("R10 period untouched", 32'h00C, 10);
    wr(32'h03C, 32'hF);
    rd_check("R10 int enable", 32'h03C, 0);
    wr(32'h040, 32'hF);
    rd_check("R10 int status", 32'h040, 0);
    wr(32'h04C, 32'h1234);
    rd_check("R10 wd slot", 32'h04C, 0);

    // R1 alignment and stored words
    wr(32'h00D, 3);
    rd_check("R1 unaligned write", 32'h00C, 10);
    rd_check("R1 unaligned read", 32'h00E, 0);
    wr(32'h004, 32'h1234);
    rd_check("R1 selector word", 32'h004, 32'h1234);

    // R5 run needs enable and continuous
    setup(1, 0, 4, 3, 1, 1);
    measure("R5 enable only", 1, 0, 0);
    wr(32'h008, 8 << 8);
    measure("R5 continuous only", 1, 0, 0);
    wr(32'h008, 9 << 8);
    repeat (4) @(negedge clk);
    measure("R5 both", 1, 4, 2);

    // R8 stopped but inverted
    wr(32'h008, 4 << 12);
    repeat (2) @(negedge clk);
    check("R8 stopped inverted", int'(pwm), 4'b0100);

    // R12 new period at reload
    setup(0, 0, 4, 1000, 500, 9);
    repeat (5) @(negedge clk);
    wr(32'h00C, 3);
    wr(32'h010, 1);
    rd(32'h014, v);
    check("R12 old period running", int'(v > 900 && v <= 1000), 1);
    repeat (1100) @(negedge clk);
    measure("R12 new period", 0, 4, 2);

    summary();
    $finish;
  end
endmodule